// File: doc/BRIEF.md
# Banked pin interrupt controller

The controller gathers interrupt events from a wide set of raw port pins and presents them as one interrupt line per bank. It has four banks of 32 channels, so 128 channels in all. Channel k lives in bank k>>5 at bit k&31. Each bank decides which port halves feed its channels. Each channel can be masked, can be set to level or edge detection, and can have its polarity inverted.

Software programs the controller through a simple single-cycle register port. Mask, edge and invert each have a set register and a clear register, so one bit can be changed without a read-modify-write. Edge events stay latched in a request register until software writes a one to clear them. A pin-state view returns each channel's synchronized pin value after inversion. Pins pass through a two-flop synchronizer before any detection takes place.

Top module: `pint_ctrl`

## Requirements
- R1: In each bank, byte lane b of the port-map register (select code 7) feeds channel bits 8b to 8b+7. The lane's low 3 bits pick port p, and channel bit 8b+i is fed by pin p*16 + i + 8*(b&1). Even lanes take the lower half of the port and odd lanes take the upper half.
- R2: The register address is {bank[1:0], select[3:0]}. The select codes are: 0 mask set, 1 mask clear, 2 edge set, 3 edge clear, 4 invert set, 5 invert clear, 6 request, 7 port map and 8 pin state. Any other code reads 0. Writing ones to code 0 sets those mask bits and writing ones to code 1 clears them. Zero bits in the written data leave their mask bits unchanged. Reading either code 0 or code 1 returns the current mask.
- R3: Edge set (code 2) and edge clear (code 3) work as a pair, in the same way as the mask pair. Reading either code returns the current edge value. Edge bit 1 selects edge detection and edge bit 0 selects level detection.
- R4: Invert set (code 4) and invert clear (code 5) work as a pair, in the same way as the mask pair. Invert bit 1 makes the channel active-low, or falling-edge in edge mode. Invert bit 0 makes it active-high, or rising-edge. The pin-state register (code 8) returns the synchronized pin value XOR the invert bit.
- R5: In level mode a request bit follows the channel's active level. Writing one to that request bit has no lasting effect.
- R6: In edge mode a request bit sets when the channel goes from inactive to active. It then stays set after the pin returns to inactive, until a one is written to that bit of the request register (code 6).
- R7: If an edge event and a request-clear write land on the same bit in the same cycle, the request bit ends up set.
- R8: irq_o[b] is high exactly when bank b has at least one request bit whose mask bit is also set.
- R9: After reset, mask, edge, invert, port map and request are all zero, and every irq_o bit is low.
- R10: A pin change shows in the pin-state register after two clock edges and in the request register after three clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 128 | Raw port pins, 8 ports of 16 pins |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register address {bank, select} |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the addressed register, combinational |
| irq_o | output | 4 | Per-bank interrupt lines |

## Verification
Several properties are checked on every cycle:
- writes to a set or clear register take effect on the written bits in the following cycle;
- a level-mode request bit matches the active level of the previous cycle;
- an edge-mode request bit drops only when a clear write is present;
- a bank's interrupt line never rises while its whole mask is zero.

Other behaviour can only be shown by the bench's scenarios:
- the mapping of byte lanes and port halves onto channels;
- polarity as seen through the pin state;
- the exact synchronizer latency;
- the event-beats-clear collision.

// File: rtl/pint_pkg.sv
package pint_pkg;
  typedef enum logic [3:0] {
    SEL_MSK_SET = 4'd0,
    SEL_MSK_CLR = 4'd1,
    SEL_EDG_SET = 4'd2,
    SEL_EDG_CLR = 4'd3,
    SEL_INV_SET = 4'd4,
    SEL_INV_CLR = 4'd5,
    SEL_REQ     = 4'd6,
    SEL_MAP     = 4'd7,
    SEL_PIN     = 4'd8
  } reg_sel_e;
endpackage

// File: rtl/pint_sync.sv
module pint_sync #(
  parameter int W = 128
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pint_setclr.sv
module pint_setclr #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= '0;
    else if (set_i) q <= q | data_i;
    else if (clr_i) q <= q & ~data_i;
  end

  assign q_o = q;

  AST_SET_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((q & $past(data_i)) == $past(data_i))); // R2
  AST_CLR_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> ((q & $past(data_i)) == '0)); // R2
  AST_ZERO_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i || clr_i) |=> (((q ^ $past(q)) & ~$past(data_i)) == '0)); // R2
endmodule

// File: rtl/pint_bank.sv
module pint_bank
  import pint_pkg::*;
#(
  parameter int CH        = 32,
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_PORTS*PORT_W-1:0] pins_i,
  input  logic                        we_i,
  input  logic [3:0]                  sel_i,
  input  logic [CH-1:0]               wdata_i,
  output logic [CH-1:0]               rdata_o,
  output logic                        irq_o
);
  localparam int LANE_W    = PORT_W / 2;
  localparam int NUM_LANES = CH / LANE_W;
  localparam int PSEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  logic [CH-1:0] mask_q, edge_q, inv_q, map_q, req_q, act_prev_q;
  logic [CH-1:0] lane_raw, active, clr_req, rise, req_d;

  pint_setclr #(.W(CH)) i_mask (
    .clk_i, .rst_ni,
    .set_i(we_i && sel_i == SEL_MSK_SET), .clr_i(we_i && sel_i == SEL_MSK_CLR),
    .data_i(wdata_i), .q_o(mask_q));
  pint_setclr #(.W(CH)) i_edge (
    .clk_i, .rst_ni,
    .set_i(we_i && sel_i == SEL_EDG_SET), .clr_i(we_i && sel_i == SEL_EDG_CLR),
    .data_i(wdata_i), .q_o(edge_q));
  pint_setclr #(.W(CH)) i_inv (
    .clk_i, .rst_ni,
    .set_i(we_i && sel_i == SEL_INV_SET), .clr_i(we_i && sel_i == SEL_INV_CLR),
    .data_i(wdata_i), .q_o(inv_q));

  // each byte lane picks a port; odd lanes take the upper half
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [PSEL_W-1:0] port_sel;
    assign port_sel = map_q[l*LANE_W +: PSEL_W];
    assign lane_raw[l*LANE_W +: LANE_W] =
      pins_i[PORT_W*int'(port_sel) + (l % 2)*LANE_W +: LANE_W];
  end

  assign active  = lane_raw ^ inv_q;
  assign clr_req = (we_i && sel_i == SEL_REQ) ? wdata_i : '0;
  assign rise    = active & ~act_prev_q;
  // new edge wins over a same-cycle clear
  assign req_d   = (~edge_q & active) | (edge_q & (rise | (req_q & ~clr_req)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q      <= '0;
      req_q      <= '0;
      act_prev_q <= '0;
    end else begin
      if (we_i && sel_i == SEL_MAP) map_q <= wdata_i;
      req_q      <= req_d;
      act_prev_q <= active;
    end
  end

  always_comb begin
    unique case (sel_i)
      SEL_MSK_SET, SEL_MSK_CLR: rdata_o = mask_q;
      SEL_EDG_SET, SEL_EDG_CLR: rdata_o = edge_q;
      SEL_INV_SET, SEL_INV_CLR: rdata_o = inv_q;
      SEL_REQ:                  rdata_o = req_q;
      SEL_MAP:                  rdata_o = map_q;
      SEL_PIN:                  rdata_o = active;
      default:                  rdata_o = '0;
    endcase
  end

  assign irq_o = |(req_q & mask_q);

  AST_LEVEL_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((req_q ^ $past(active)) & ~$past(edge_q)) == '0)); // R5
  AST_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(req_q) & $past(edge_q) & ~$past(clr_req) & ~req_q) == '0)); // R6
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_q != '0)); // R8
endmodule

// File: rtl/pint_ctrl.sv
module pint_ctrl #(
  parameter int NUM_BANKS = 4,
  parameter int CH        = 32,
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = 16,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W   = BANK_W + 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_PORTS*PORT_W-1:0] pins_i,
  input  logic                        reg_we_i,
  input  logic [ADDR_W-1:0]           reg_addr_i,
  input  logic [CH-1:0]               reg_wdata_i,
  output logic [CH-1:0]               reg_rdata_o,
  output logic [NUM_BANKS-1:0]        irq_o
);
  localparam int NPINS = NUM_PORTS * PORT_W;

  logic [NPINS-1:0]  pins_sync;
  logic [BANK_W-1:0] addr_bank;
  logic [CH-1:0]     bank_rdata [NUM_BANKS];

  assign addr_bank = reg_addr_i[ADDR_W-1 -: BANK_W];

  pint_sync #(.W(NPINS)) i_sync (
    .clk_i, .rst_ni, .d_i(pins_i), .q_o(pins_sync));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    pint_bank #(.CH(CH), .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) i_bank (
      .clk_i, .rst_ni,
      .pins_i (pins_sync),
      .we_i   (reg_we_i && addr_bank == BANK_W'(b)),
      .sel_i  (reg_addr_i[3:0]),
      .wdata_i(reg_wdata_i),
      .rdata_o(bank_rdata[b]),
      .irq_o  (irq_o[b]));
  end

  assign reg_rdata_o = bank_rdata[addr_bank];

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (irq_o == '0)); // R9
endmodule

// File: tb/test_pint_ctrl.sv
module test_pint_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] MSK_SET = 4'd0, MSK_CLR = 4'd1, EDG_SET = 4'd2, EDG_CLR = 4'd3,
                         INV_SET = 4'd4, INV_CLR = 4'd5, REQ = 4'd6, MAP = 4'd7, PIN = 4'd8;

  typedef struct packed {
    logic [1:0] bank;
    logic [4:0] bit_idx;
    logic [2:0] port;
    logic       inv;
    logic       pin;
    logic       exp_req;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 5'd3,  3'd2, 1'b0, 1'b1, 1'b1},
    '{2'd1, 5'd12, 3'd5, 1'b0, 1'b1, 1'b1},
    '{2'd2, 5'd17, 3'd7, 1'b1, 1'b1, 1'b0},
    '{2'd3, 5'd31, 3'd3, 1'b1, 1'b0, 1'b1},
    '{2'd0, 5'd9,  3'd1, 1'b0, 1'b0, 1'b0},
    '{2'd1, 5'd22, 3'd6, 1'b1, 1'b0, 1'b1},
    '{2'd2, 5'd26, 3'd4, 1'b0, 1'b1, 1'b1},
    '{2'd3, 5'd0,  3'd7, 1'b0, 1'b1, 1'b1}
  };

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [127:0] pins = '0;
  logic         we = 1'b0;
  logic [5:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [3:0]   irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pint_ctrl i_pint_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .pins_i(pins), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int bank, logic [3:0] sel, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = {2'(bank), sel}; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(int bank, logic [3:0] sel, output logic [31:0] v);
    addr = {2'(bank), sel};
    #1 v = rdata;
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    wait_clk(3);
    chk("R9 irq in reset", 32'(irq), 32'h0);
    rst_ni = 1'b1;
    wait_clk(1);
    rd(1, MSK_SET, v); chk("R9 mask", v, 32'h0);
    rd(2, MAP, v);     chk("R9 map", v, 32'h0);
    rd(3, REQ, v);     chk("R9 request", v, 32'h0);
    rd(0, EDG_CLR, v); chk("R9 edge", v, 32'h0);
    chk("R9 irq", 32'(irq), 32'h0);

    // table: lane mapping, polarity, level detection
    for (int i = 0; i < 8; i++) begin
      vec_t e;
      int lane, pin_idx, bank, bitn;
      e = VEC[i];
      bank = int'(e.bank);
      bitn = int'(e.bit_idx);
      lane = bitn / 8;
      pin_idx = int'(e.port) * 16 + bitn % 8 + 8 * (lane % 2);
      wr(bank, MAP, 32'(e.port) << (8 * lane));
      if (e.inv) wr(bank, INV_SET, 32'h1 << bitn);
      pins[pin_idx] = e.pin;
      wait_clk(3);
      rd(bank, REQ, v); chk($sformatf("R1 vec%0d request", i), 32'(v[bitn]), 32'(e.exp_req));
      rd(bank, PIN, v); chk($sformatf("R4 vec%0d pinstate", i), 32'(v[bitn]), 32'(e.exp_req));
      pins = '0;
      wr(bank, INV_CLR, 32'hFFFF_FFFF);
      wr(bank, MAP, 32'h0);
      wait_clk(3);
    end

    // R2 mask pair
    wr(1, MSK_SET, 32'hF0F0_0001);
    rd(1, MSK_SET, v); chk("R2 mask set", v, 32'hF0F0_0001);
    wr(1, MSK_CLR, 32'h0000_0001);
    rd(1, MSK_CLR, v); chk("R2 mask clear", v, 32'hF0F0_0000);
    wr(1, MSK_SET, 32'h0000_000F);
    rd(1, MSK_SET, v); chk("R2 mask keep", v, 32'hF0F0_000F);
    chk("R8 no request no irq", 32'(irq), 32'h0);
    wr(1, MSK_CLR, 32'hFFFF_FFFF);
    rd(1, MSK_SET, v); chk("R2 mask all clear", v, 32'h0);
    rd(1, 4'd12, v);   chk("R2 unused code", v, 32'h0);

    // R3 edge pair
    wr(3, EDG_SET, 32'h00FF_0000);
    wr(3, EDG_CLR, 32'h000F_0000);
    rd(3, EDG_SET, v); chk("R3 edge pair", v, 32'h00F0_0000);
    wr(3, EDG_CLR, 32'hFFFF_FFFF);
    rd(3, EDG_CLR, v); chk("R3 edge clear", v, 32'h0);

    // R4 invert pair and pin state
    wr(0, INV_SET, 32'h5);
    rd(0, INV_CLR, v); chk("R4 invert read", v, 32'h5);
    rd(0, PIN, v);     chk("R4 pinstate inverted", v, 32'h5);
    wr(0, INV_CLR, 32'hFFFF_FFFF);
    wait_clk(3);

    // R5 level mode on bank 3 bit 5 (pin 5)
    wr(3, MSK_SET, 32'h20);
    pins[5] = 1'b1;
    wait_clk(3);
    rd(3, REQ, v); chk("R5 level high", 32'(v[5]), 32'h1);
    chk("R8 irq bank3", 32'(irq), 32'h8);
    wr(3, REQ, 32'h20);
    rd(3, REQ, v); chk("R5 clear ignored", 32'(v[5]), 32'h1);
    pins[5] = 1'b0;
    wait_clk(3);
    rd(3, REQ, v); chk("R5 level low", 32'(v[5]), 32'h0);
    chk("R8 irq drops", 32'(irq), 32'h0);
    pins[5] = 1'b1;
    wait_clk(3);
    wr(3, MSK_CLR, 32'h20);
    rd(3, REQ, v); chk("R8 masked request", 32'(v[5]), 32'h1);
    chk("R8 masked irq", 32'(irq), 32'h0);
    pins[5] = 1'b0;
    wait_clk(3);

    // R6 edge mode on bank 2 bit 0 (pin 0)
    wr(2, EDG_SET, 32'h1);
    wr(2, MSK_SET, 32'h1);
    pins[0] = 1'b1;
    wait_clk(3);
    rd(2, REQ, v); chk("R6 rise latched", 32'(v[0]), 32'h1);
    chk("R8 irq bank2", 32'(irq), 32'h4);
    pins[0] = 1'b0;
    wait_clk(4);
    rd(2, REQ, v); chk("R6 held after pin low", 32'(v[0]), 32'h1);
    wr(2, REQ, 32'h1);
    rd(2, REQ, v); chk("R6 write one clears", 32'(v[0]), 32'h0);
    chk("R6 irq cleared", 32'(irq), 32'h0);
    // falling-edge under invert
    wr(2, INV_SET, 32'h1);
    wait_clk(3);
    wr(2, REQ, 32'h1);
    rd(2, REQ, v); chk("R4 cleared before fall test", 32'(v[0]), 32'h0);
    pins[0] = 1'b1;
    wait_clk(3);
    rd(2, REQ, v); chk("R4 inverted rise ignored", 32'(v[0]), 32'h0);
    pins[0] = 1'b0;
    wait_clk(3);
    rd(2, REQ, v); chk("R4 falling edge", 32'(v[0]), 32'h1);
    wr(2, INV_CLR, 32'h1);
    wr(2, REQ, 32'h1);
    wr(2, MSK_CLR, 32'h1);

    // R7 event and clear in the same cycle, bank 2 bit 1 (pin 1)
    wr(2, EDG_SET, 32'h2);
    @(negedge clk);
    pins[1] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    we = 1'b1; addr = {2'd2, REQ}; wdata = 32'h2;
    @(negedge clk);
    we = 1'b0;
    rd(2, REQ, v); chk("R7 event wins", 32'(v[1]), 32'h1);
    wr(2, REQ, 32'h2);
    rd(2, REQ, v); chk("R6 later clear", 32'(v[1]), 32'h0);
    pins[1] = 1'b0;
    wr(2, EDG_CLR, 32'hFFFF_FFFF);
    wait_clk(3);

    // R10 latency, bank 0 bit 3 (pin 3), level mode
    @(negedge clk);
    pins[3] = 1'b1;
    @(negedge clk);
    rd(0, PIN, v); chk("R10 pinstate after 1 edge", 32'(v[3]), 32'h0);
    @(negedge clk);
    rd(0, PIN, v); chk("R10 pinstate after 2 edges", 32'(v[3]), 32'h1);
    rd(0, REQ, v); chk("R10 request after 2 edges", 32'(v[3]), 32'h0);
    @(negedge clk);
    rd(0, REQ, v); chk("R10 request after 3 edges", 32'(v[3]), 32'h1);
    pins[3] = 1'b0;
    wait_clk(3);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule